// File: doc/BRIEF.md
# Left-Justified PCM Audio Serializer

This block plays mono 16-bit PCM samples from a synchronous read-only sample memory through a three-wire serial audio DAC link. It runs entirely on the master clock (1.024 MHz, 128 times the 8 kHz sample rate). It divides that clock by four to make a 256 kHz bit clock, giving 32 bit periods per frame: 16 for the left channel and 16 for the right. The word clock is low for the left channel and high for the right. The same sample goes out on both channels.

Each stored word holds its two bytes in the reverse of the order the converter needs. The block reverses them before the word is shifted out MSB first. A run-time mode input chooses between two alignments. In left-justified alignment the MSB sits at the word-clock edge. In I2S alignment the MSB comes one bit period later. The read address steps once per frame and wraps after a configurable number of entries. Each fetch is issued half a frame ahead of use, so the memory's one-cycle read latency never stalls the stream.

Top module: `pcm_lj_serializer`

## Requirements
- R1: `bclk` has a period of 4 master clocks. It is low for the first 2 clocks and high for the last 2 of each bit period, and each bit period begins with a falling `bclk` edge.
- R2: A frame is 32 bit periods. `wclk` is 0 during bit periods 0..15 (left) and 1 during 16..31 (right), and it changes only together with a falling `bclk` edge.
- R3: `sdata` changes only together with a falling `bclk` edge, so it is stable across every rising edge.
- R4: A stored word is sent with its bytes exchanged: memory value 0xABCD is transmitted as 0xCDAB, most significant bit first.
- R5: With `i2s_mode`=0 (left-justified), bit period k of each channel carries bit 15-k of the frame's swapped sample, so the MSB starts at the `wclk` transition. Both channels carry the same sample.
- R6: With `i2s_mode`=1, data is delayed by one bit period. Bit period 0 of each channel carries bit 0 (the LSB) of the word sent in the preceding channel slot. Bit period k≥1 carries bit 16-k of the current sample, so the MSB is valid at the second rising `bclk` after the `wclk` change. Bit period 0 of the first frame after reset carries 0.
- R7: `i2s_mode` is sampled only at the start of each frame (the falling `bclk` edge where `wclk` goes to 0). Changes during a frame take effect at the next frame.
- R8: `mem_addr` advances by one at the start of each frame's right channel and wraps from DEPTH-1 to 0. Frame n therefore uses the word at address n mod DEPTH, and `mem_rdata` is expected one master clock after `mem_addr`.
- R9: While `rst` is high: `mem_addr`=0, `sdata`=0, `wclk`=0, `bclk`=1. The first clock edge after release starts a left channel carrying the word at address 0. `rst` must be held for at least 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (128 × sample rate) |
| rst | input | 1 | Synchronous active-high reset |
| i2s_mode | input | 1 | 0 = left-justified alignment, 1 = I2S alignment |
| mem_addr | output | ADDR_W | Read address to the sample memory |
| mem_rdata | input | SAMPLE_W | Stored word, valid one clock after `mem_addr` |
| bclk | output | 1 | Serial bit clock (master / BCLK_DIV) |
| wclk | output | 1 | Word clock, low for left channel |
| sdata | output | 1 | Serial data, MSB first |

## Verification
At the start of a frame, three things happen on the same master-clock edge: the word clock changes, the alignment mode is latched, and, in left-justified mode, a freshly fetched word is loaded and its MSB driven. In I2S mode that same edge must instead still output the LSB of the previous word. The bench provokes this collision by changing alignment from frame to frame. It also flips `i2s_mode` in the middle of selected frames. Every recorded bit stream is compared with one rebuilt from the stored words and the mode present at each frame start. A short memory depth makes the address wrap coincide with these mode switches.

// File: rtl/audtx_pkg.sv
package audtx_pkg;
  typedef enum logic {
    FMT_LEFT_JUST = 1'b0,
    FMT_I2S       = 1'b1
  } audtx_fmt_e;
endpackage

// File: rtl/audtx_timing.sv
module audtx_timing #(
  parameter int DIV    = 4,
  parameter int SLOTS  = 32,
  parameter int PH_W   = (DIV > 1) ? $clog2(DIV) : 1,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              bit_start,
  output logic [SLOT_W-1:0] slot_next,
  output logic              bclk
);
  localparam int HALF = DIV / 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);

  logic [PH_W-1:0]   phase;
  logic [SLOT_W-1:0] slot;

  assign bit_start = (phase == PH_LAST);
  assign slot_next = slot + SLOT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_LAST;
      slot  <= SLOT_W'(SLOTS - 1);
      bclk  <= 1'b1;
    end else begin
      if (bit_start) begin
        phase <= '0;
        slot  <= slot_next;
        bclk  <= 1'b0;
      end else begin
        phase <= phase + PH_W'(1);
        if (phase == PH_RISE) bclk <= 1'b1;
      end
    end
  end

  // R1: the rising bit-clock edge lands at the middle of the bit period
  p_bclk_rise_mid_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(bclk) |-> (phase == PH_W'(HALF)));

  // R1: the bit clock falls exactly when a new bit period starts
  p_bclk_fall_start_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(bclk) |-> (phase == '0));
endmodule

// File: rtl/audtx_fetch.sv
module audtx_fetch #(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 32000,
  parameter int ADDR_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic [SAMPLE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [SAMPLE_W-1:0] word_swapped
);
  localparam int NBYTES = SAMPLE_W / 8;
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
    end else if (adv) begin
      mem_addr <= (mem_addr == ADDR_LAST) ? '0 : mem_addr + ADDR_W'(1);
    end
  end

  // reverse byte order of each stored word
  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign word_swapped[b*8 +: 8] = mem_rdata[(NBYTES-1-b)*8 +: 8];
  end

  // R8: address stays inside the memory
  always_comb begin
    if (!rst) a_addr_range_r8: assert (int'(mem_addr) < DEPTH);
  end

  // R8: wrap after the last entry
  p_addr_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && mem_addr == ADDR_LAST) |=> (mem_addr == '0));

  // R8: address only moves on the once-per-frame step
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(mem_addr));
endmodule

// File: rtl/audtx_shift.sv
module audtx_shift
  import audtx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOTS    = 2 * SAMPLE_W,
  parameter int SLOT_W   = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_start,
  input  logic [SLOT_W-1:0]   slot_next,
  input  logic                i2s_mode,
  input  logic [SAMPLE_W-1:0] word_in,
  output logic                sdata,
  output logic                wclk
);
  localparam int CH_W = $clog2(SAMPLE_W);

  audtx_fmt_e          mode_q;
  audtx_fmt_e          fmt_now;
  logic [SAMPLE_W-1:0] cur;
  logic [SAMPLE_W-1:0] word_src;
  logic [SLOT_W-1:0]   pos;
  logic [CH_W-1:0]     bit_idx;
  logic                frame_start;
  logic                load;

  assign frame_start = bit_start && (slot_next == '0);

  always_comb begin
    fmt_now  = frame_start ? audtx_fmt_e'(i2s_mode) : mode_q;
    // stream position: I2S runs one bit period behind the word clock
    pos      = slot_next - ((fmt_now == FMT_I2S) ? SLOT_W'(1) : SLOT_W'(0));
    bit_idx  = CH_W'(SAMPLE_W - 1) - pos[CH_W-1:0];
    load     = bit_start && (pos == '0);
    word_src = load ? word_in : cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= FMT_LEFT_JUST;
      cur    <= '0;
      sdata  <= 1'b0;
      wclk   <= 1'b0;
    end else if (bit_start) begin
      if (frame_start) mode_q <= fmt_now;
      if (load)        cur    <= word_in;
      sdata <= word_src[bit_idx];
      wclk  <= slot_next[SLOT_W-1];
    end
  end

  // R5: left-justified MSB coincides with every word-clock change
  p_lj_msb_at_wclk_r5: assert property (@(posedge clk) disable iff (rst)
    (!$stable(wclk) && mode_q == FMT_LEFT_JUST) |-> (sdata == cur[SAMPLE_W-1]));

  // R6: in I2S the bit at the word-clock change is the trailing LSB
  p_i2s_lsb_at_wclk_r6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(wclk) && mode_q == FMT_I2S) |-> (sdata == cur[0]));

  // R7: alignment mode only changes at a frame boundary
  p_mode_frame_only_r7: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(mode_q));
endmodule

// File: rtl/pcm_lj_serializer.sv
module pcm_lj_serializer #(
  parameter int SAMPLE_W = 16,
  parameter int BCLK_DIV = 4,
  parameter int DEPTH    = 32000,
  parameter int ADDR_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                i2s_mode,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [SAMPLE_W-1:0] mem_rdata,
  output logic                bclk,
  output logic                wclk,
  output logic                sdata
);
  localparam int SLOTS  = 2 * SAMPLE_W;
  localparam int SLOT_W = $clog2(SLOTS);

  logic              bit_start;
  logic [SLOT_W-1:0] slot_next;
  logic [SAMPLE_W-1:0] word_swapped;
  logic              adv;

  // fetch next word when the right channel begins: half a frame of slack
  assign adv = bit_start && (slot_next == SLOT_W'(SAMPLE_W));

  audtx_timing #(.DIV(BCLK_DIV), .SLOTS(SLOTS)) u_timing (
    .clk       (clk),
    .rst       (rst),
    .bit_start (bit_start),
    .slot_next (slot_next),
    .bclk      (bclk)
  );

  audtx_fetch #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fetch (
    .clk          (clk),
    .rst          (rst),
    .adv          (adv),
    .mem_rdata    (mem_rdata),
    .mem_addr     (mem_addr),
    .word_swapped (word_swapped)
  );

  audtx_shift #(.SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .bit_start (bit_start),
    .slot_next (slot_next),
    .i2s_mode  (i2s_mode),
    .word_in   (word_swapped),
    .sdata     (sdata),
    .wclk      (wclk)
  );

  // R3: data never moves away from a falling bit-clock edge
  p_sdata_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $fell(bclk));

  // R2: word clock changes only with a falling bit-clock edge
  p_wclk_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(wclk) |-> $fell(bclk));
endmodule

// File: tb/tb_pcm_lj_serializer.sv
module tb_pcm_lj_serializer;
  localparam int D    = 6;
  localparam int W    = 16;
  localparam int AW   = $clog2(D);
  localparam int NF   = 12;
  localparam int MAXG = NF * 32;

  // per frame: {glitch mid-frame, i2s_mode at frame start}
  localparam logic [1:0] VEC [NF] = '{
    2'b00, 2'b00, 2'b01, 2'b11, 2'b00, 2'b01,
    2'b10, 2'b01, 2'b01, 2'b00, 2'b10, 2'b01
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          i2s_mode = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  mem_rdata;
  logic          bclk, wclk, sdata;
  logic [W-1:0]  mem [D];

  int  tests = 0, fails = 0, cyc = 0;
  bit  mon_en = 1'b0, done = 1'b0;
  bit  sd0 [MAXG];
  bit  wc0 [MAXG];
  int  fmode [NF];
  bit  fglitch [NF];

  always #5 clk = ~clk;

  pcm_lj_serializer #(.SAMPLE_W(W), .BCLK_DIV(4), .DEPTH(D), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .i2s_mode(i2s_mode), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .bclk(bclk), .wclk(wclk), .sdata(sdata)
  );

  always @(posedge clk) mem_rdata <= mem[mem_addr];
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  function automatic logic [15:0] swap16(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  function automatic bit exp_bit(input int f, input int s);
    logic [15:0] w, prev;
    w    = swap16(mem[f % D]);
    prev = (f == 0) ? 16'h0 : swap16(mem[(f - 1) % D]);
    if (fmode[f] == 0) return w[15 - (s % 16)];
    if (s == 0)  return prev[0];
    if (s == 16) return w[0];
    return w[15 - ((s % 16) - 1)];
  endfunction

  // monitor: per-slot timing checks and bit capture
  always @(negedge clk) begin
    if (mon_en && !rst && cyc >= 1) begin
      automatic int g  = (cyc - 1) / 4;
      automatic int ph = (cyc - 1) % 4;
      automatic int f  = g / 32;
      if (g < MAXG) begin
        tests++;
        if (bclk !== (ph >= 2)) begin
          fails++;
          $display("FAIL R1 cyc %0d: bclk %b expected %b", cyc, bclk, ph >= 2);
        end
        if (ph == 0) begin
          sd0[g] = sdata;
          wc0[g] = wclk;
        end else begin
          tests++;
          if (sdata !== sd0[g] || wclk !== wc0[g]) begin
            fails++;
            $display("FAIL R3 cyc %0d: sdata/wclk %b%b expected %b%b",
                     cyc, sdata, wclk, sd0[g], wc0[g]);
          end
        end
        if (g % 32 == 15 && ph == 3) begin
          tests++;
          if (mem_addr !== AW'(f % D)) begin
            fails++;
            $display("FAIL R8 frame %0d: addr %0d expected %0d", f, mem_addr, f % D);
          end
        end
        if (g % 32 == 16 && ph == 0) begin
          tests++;
          if (mem_addr !== AW'((f + 1) % D)) begin
            fails++;
            $display("FAIL R8 frame %0d: addr %0d expected %0d", f, mem_addr, (f + 1) % D);
          end
        end
      end
    end
  end

  task automatic drive_run(input int n);
    @(negedge clk);
    rst    = 1'b0;
    mon_en = 1'b1;
    for (int f = 0; f < n; f++) begin
      i2s_mode   = VEC[f][0];
      fmode[f]   = int'(VEC[f][0]);
      fglitch[f] = VEC[f][1];
      if (VEC[f][1]) begin
        repeat (60) @(negedge clk);
        i2s_mode = ~i2s_mode;   // R7: mid-frame change must be ignored
        repeat (68) @(negedge clk);
      end else begin
        repeat (128) @(negedge clk);
      end
    end
    repeat (2) @(negedge clk);
    mon_en = 1'b0;
  endtask

  task automatic check_frames(input int n);
    for (int f = 0; f < n; f++) begin
      logic [31:0] got, exp, wgot, wexp;
      for (int s = 0; s < 32; s++) begin
        got[31 - s]  = sd0[f * 32 + s];
        exp[31 - s]  = exp_bit(f, s);
        wgot[31 - s] = wc0[f * 32 + s];
        wexp[31 - s] = (s >= 16);
      end
      tests++;
      if (got !== exp) begin
        fails++;
        $display("FAIL %s%s frame %0d: bits %h expected %h",
                 fmode[f] ? "R6" : "R5", fglitch[f] ? "/R7" : "", f, got, exp);
      end
      tests++;  // R2 word clock shape
      if (wgot !== wexp) begin
        fails++;
        $display("FAIL R2 frame %0d: wclk %h expected %h", f, wgot, wexp);
      end
    end
  endtask

  initial begin
    mem[0] = 16'hABCD; mem[1] = 16'h8001; mem[2] = 16'h00FF;
    mem[3] = 16'h7F80; mem[4] = 16'hFFFF; mem[5] = 16'h0000;
    repeat (4) @(negedge clk);
    tests++;  // R9 reset state
    if ({bclk, wclk, sdata} !== 3'b100 || mem_addr !== '0) begin
      fails++;
      $display("FAIL R9 reset: bclk/wclk/sdata %b%b%b addr %0d expected 100 addr 0",
               bclk, wclk, sdata, mem_addr);
    end
    drive_run(NF);
    check_frames(NF);
    tests++;  // R4 explicit swap of 0xABCD in left-justified frame 0
    begin
      logic [15:0] lw;
      for (int s = 0; s < 16; s++) lw[15 - s] = sd0[s];
      if (lw !== 16'hCDAB) begin
        fails++;
        $display("FAIL R4 frame 0 left word %h expected cdab", lw);
      end
    end
    // mid-stream reset
    rst = 1'b1;
    repeat (3) @(negedge clk);
    tests++;
    if ({bclk, wclk, sdata} !== 3'b100 || mem_addr !== '0) begin
      fails++;
      $display("FAIL R9 mid reset: bclk/wclk/sdata %b%b%b addr %0d expected 100 addr 0",
               bclk, wclk, sdata, mem_addr);
    end
    drive_run(2);
    check_frames(2);  // R9: restarts at address 0, left channel first
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule